// File: doc/BRIEF.md
# Four-Multiplier Sum-of-Products Unit

This block forms four products A_i × B_i in parallel and combines them in two pairs. Within each pair a per-cycle control selects add or subtract. The two pair results are summed together with a cascade word from an upstream unit. A feedback term is added as well: it is either the previous result, so the unit accumulates, or zero, so the unit loads a fresh value. The signedness of all A operands and of all B operands can change on every cycle.

Operands and controls pass through one input register stage. The arithmetic then feeds one output register stage, which also serves as the accumulator. Each stage has its own asynchronous and synchronous clear, and both stages share one clock enable.

A scan mode turns the four A input registers into a shift chain, which lets a data stream pass from one multiplier to the next. The last A register is always visible on the scan output.

Top module: `sop4_unit`

## Requirements
- R1: Each multiplier i (0..3) multiplies A slice `a_bus[i*A_W +: A_W]` by B slice `b_bus[i*B_W +: B_W]`. An A operand is read as two's complement when `a_signed`=1 and as unsigned when it is 0. `b_signed` does the same for the B operands.
- R2: `pair_add[0]`=1 gives product0 + product1, and `pair_add[0]`=0 gives product0 − product1.
- R3: `pair_add[1]`=1 gives product2 + product3, and `pair_add[1]`=0 gives product2 − product3.
- R4: The next result is pair0 + pair1 + `cas_in` (signed) + F. F is the current `result` when `acc_load`=0, and F is zero when `acc_load`=1.
- R5: Inputs sampled at clock edge k appear on `result` after edge k+1.
- R6: When `scan_sel`=1, A register 0 loads `scan_in` and A register i loads A register i−1. `scan_out` always shows A register 3, so a value on `scan_in` reaches `scan_out` after four enabled edges.
- R7: When `en`=0 and no clear is active, both register stages hold their values.
- R8: `sclr[0]` clears the input stage and `sclr[1]` clears the output stage at the next edge, whatever the value of `en`.
- R9: `aclr[0]` or `aclr[1]` clears its stage immediately, without a clock edge. `rst_n`=0 clears both stages.
- R10: `result` is a two's complement word RES_W = A_W+B_W+4 bits wide. Accumulation wraps modulo 2^RES_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of both stages |
| en | input | 1 | Clock enable shared by both stages |
| aclr | input | 2 | Asynchronous clear; bit 0 is the input stage, bit 1 the output stage |
| sclr | input | 2 | Synchronous clear; bit 0 is the input stage, bit 1 the output stage |
| a_bus | input | 4*A_W | Four A operands, multiplier i in slice i |
| b_bus | input | 4*B_W | Four B operands, multiplier i in slice i |
| a_signed | input | 1 | 1: A operands are signed |
| b_signed | input | 1 | 1: B operands are signed |
| pair_add | input | 2 | Bit k: 1 adds, 0 subtracts, for pair k |
| acc_load | input | 1 | 1: drop the accumulator feedback |
| cas_in | input | A_W+B_W+4 | Signed cascade word from an upstream unit |
| scan_sel | input | 1 | 1: A registers form a shift chain |
| scan_in | input | A_W | Head of the A shift chain |
| scan_out | output | A_W | A register of multiplier 3 |
| result | output | A_W+B_W+4 | Registered sum, also the accumulator |

## Verification
The bound checker watches every cycle for the clearing behaviour, which covers immediate clearing and one-edge synchronous clearing of each stage. It also checks that the result holds while the enable is low, and that the scan chain delivers its head value exactly four enabled edges later. The arithmetic cannot be seen by any single-cycle property: signed and unsigned products, add or subtract per pair, the cascade and feedback terms, the two-edge latency, and wrap-around during long accumulation. These are shown only by the bench's random and directed scenarios, compared against its own model.

// File: rtl/sop4_pkg.sv
package sop4_pkg;
  localparam int NUM_MUL  = 4;
  localparam int NUM_PAIR = NUM_MUL / 2;
  localparam int GUARD_W  = 2;

  typedef enum logic {
    COMB_SUB = 1'b0,
    COMB_ADD = 1'b1
  } comb_op_e;
endpackage

// File: rtl/sop4_in_stage.sv
module sop4_in_stage
  import sop4_pkg::*;
#(
  parameter int A_W   = 18,
  parameter int B_W   = 18,
  parameter int RES_W = A_W + B_W + 4
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    sclr,
  input  logic                    en,
  input  logic [NUM_MUL*A_W-1:0]  a_bus,
  input  logic [NUM_MUL*B_W-1:0]  b_bus,
  input  logic                    a_signed,
  input  logic                    b_signed,
  input  logic [NUM_PAIR-1:0]     pair_add,
  input  logic                    acc_load,
  input  logic [RES_W-1:0]        cas_in,
  input  logic                    scan_sel,
  input  logic [A_W-1:0]          scan_in,
  output logic [NUM_MUL*A_W-1:0]  a_q,
  output logic [NUM_MUL*B_W-1:0]  b_q,
  output logic                    a_signed_q,
  output logic                    b_signed_q,
  output logic [NUM_PAIR-1:0]     pair_add_q,
  output logic                    acc_load_q,
  output logic [RES_W-1:0]        cas_q,
  output logic [A_W-1:0]          scan_out
);
  logic [NUM_MUL*A_W-1:0] a_src;
  logic [NUM_MUL*A_W-1:0] a_d;
  logic [NUM_MUL*B_W-1:0] b_d;
  logic                   a_signed_d, b_signed_d, acc_load_d;
  logic [NUM_PAIR-1:0]    pair_add_d;
  logic [RES_W-1:0]       cas_d;

  // operand source per multiplier: parallel bus or shift chain
  generate
    for (genvar i = 0; i < NUM_MUL; i++) begin : g_src
      if (i == 0) begin : g_head
        assign a_src[i*A_W +: A_W] = scan_sel ? scan_in : a_bus[i*A_W +: A_W];
      end else begin : g_link
        assign a_src[i*A_W +: A_W] = scan_sel ? a_q[(i-1)*A_W +: A_W]
                                              : a_bus[i*A_W +: A_W];
      end
    end
  endgenerate

  // next state: synchronous clear outranks enable
  always_comb begin
    a_d        = a_q;
    b_d        = b_q;
    a_signed_d = a_signed_q;
    b_signed_d = b_signed_q;
    pair_add_d = pair_add_q;
    acc_load_d = acc_load_q;
    cas_d      = cas_q;
    if (sclr) begin
      a_d        = '0;
      b_d        = '0;
      a_signed_d = 1'b0;
      b_signed_d = 1'b0;
      pair_add_d = '0;
      acc_load_d = 1'b0;
      cas_d      = '0;
    end else if (en) begin
      a_d        = a_src;
      b_d        = b_bus;
      a_signed_d = a_signed;
      b_signed_d = b_signed;
      pair_add_d = pair_add;
      acc_load_d = acc_load;
      cas_d      = cas_in;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      a_q        <= '0;
      b_q        <= '0;
      a_signed_q <= 1'b0;
      b_signed_q <= 1'b0;
      pair_add_q <= '0;
      acc_load_q <= 1'b0;
      cas_q      <= '0;
    end else begin
      a_q        <= a_d;
      b_q        <= b_d;
      a_signed_q <= a_signed_d;
      b_signed_q <= b_signed_d;
      pair_add_q <= pair_add_d;
      acc_load_q <= acc_load_d;
      cas_q      <= cas_d;
    end
  end

  assign scan_out = a_q[(NUM_MUL-1)*A_W +: A_W];
endmodule

// File: rtl/sop4_mul.sv
module sop4_mul #(
  parameter int A_W = 18,
  parameter int B_W = 18,
  parameter int P_W = A_W + B_W + 2
) (
  input  logic [A_W-1:0]        a,
  input  logic [B_W-1:0]        b,
  input  logic                  a_signed,
  input  logic                  b_signed,
  output logic signed [P_W-1:0] prod
);
  logic signed [A_W:0] a_ext;
  logic signed [B_W:0] b_ext;

  // one extra bit carries the sign for signed mode, a zero otherwise
  assign a_ext = {a_signed & a[A_W-1], a};
  assign b_ext = {b_signed & b[B_W-1], b};
  assign prod  = a_ext * b_ext;
endmodule

// File: rtl/sop4_combine.sv
module sop4_combine
  import sop4_pkg::*;
#(
  parameter int P_W   = 38,
  parameter int RES_W = P_W + GUARD_W
) (
  input  logic [NUM_MUL*P_W-1:0] prods,
  input  logic [NUM_PAIR-1:0]    pair_add,
  input  logic                   acc_load,
  input  logic [RES_W-1:0]       cas,
  input  logic [RES_W-1:0]       acc_fb,
  output logic [RES_W-1:0]       sum
);
  localparam int EXT_W = RES_W - P_W;

  logic [NUM_MUL*RES_W-1:0]  p_ext;
  logic [NUM_PAIR*RES_W-1:0] pair_sum;
  logic [RES_W-1:0]          fb_term;

  generate
    for (genvar i = 0; i < NUM_MUL; i++) begin : g_ext
      assign p_ext[i*RES_W +: RES_W] =
        {{EXT_W{prods[i*P_W + P_W - 1]}}, prods[i*P_W +: P_W]};
    end
    for (genvar k = 0; k < NUM_PAIR; k++) begin : g_pair
      always_comb begin
        if (comb_op_e'(pair_add[k]) == COMB_ADD)
          pair_sum[k*RES_W +: RES_W] = p_ext[(2*k)*RES_W +: RES_W]
                                     + p_ext[(2*k+1)*RES_W +: RES_W];
        else
          pair_sum[k*RES_W +: RES_W] = p_ext[(2*k)*RES_W +: RES_W]
                                     - p_ext[(2*k+1)*RES_W +: RES_W];
      end
    end
  endgenerate

  assign fb_term = acc_load ? '0 : acc_fb;

  always_comb begin
    sum = cas + fb_term;
    for (int k = 0; k < NUM_PAIR; k++) begin
      sum = sum + pair_sum[k*RES_W +: RES_W];
    end
  end
endmodule

// File: rtl/sop4_out_stage.sv
module sop4_out_stage #(
  parameter int RES_W = 40
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             sclr,
  input  logic             en,
  input  logic [RES_W-1:0] sum,
  output logic [RES_W-1:0] res_q
);
  logic [RES_W-1:0] res_d;

  always_comb begin
    res_d = res_q;
    if (sclr)    res_d = '0;
    else if (en) res_d = sum;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) res_q <= '0;
    else         res_q <= res_d;
  end
endmodule

// File: rtl/sop4_unit.sv
module sop4_unit
  import sop4_pkg::*;
#(
  parameter int A_W = 18,
  parameter int B_W = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         en,
  input  logic [1:0]                   aclr,
  input  logic [1:0]                   sclr,
  input  logic [4*A_W-1:0]             a_bus,
  input  logic [4*B_W-1:0]             b_bus,
  input  logic                         a_signed,
  input  logic                         b_signed,
  input  logic [1:0]                   pair_add,
  input  logic                         acc_load,
  input  logic [A_W+B_W+GUARD_W+1:0]   cas_in,
  input  logic                         scan_sel,
  input  logic [A_W-1:0]               scan_in,
  output logic [A_W-1:0]               scan_out,
  output logic [A_W+B_W+GUARD_W+1:0]   result
);
  localparam int P_W   = A_W + B_W + 2;
  localparam int RES_W = P_W + GUARD_W;

  logic                    in_arst_n, out_arst_n;
  logic [NUM_MUL*A_W-1:0]  a_q;
  logic [NUM_MUL*B_W-1:0]  b_q;
  logic                    a_signed_q, b_signed_q, acc_load_q;
  logic [NUM_PAIR-1:0]     pair_add_q;
  logic [RES_W-1:0]        cas_q;
  logic [NUM_MUL*P_W-1:0]  prods;
  logic [RES_W-1:0]        sum;

  assign in_arst_n  = rst_n & ~aclr[0];
  assign out_arst_n = rst_n & ~aclr[1];

  sop4_in_stage #(.A_W(A_W), .B_W(B_W), .RES_W(RES_W)) u_in (
    .clk        (clk),
    .arst_n     (in_arst_n),
    .sclr       (sclr[0]),
    .en         (en),
    .a_bus      (a_bus),
    .b_bus      (b_bus),
    .a_signed   (a_signed),
    .b_signed   (b_signed),
    .pair_add   (pair_add),
    .acc_load   (acc_load),
    .cas_in     (cas_in),
    .scan_sel   (scan_sel),
    .scan_in    (scan_in),
    .a_q        (a_q),
    .b_q        (b_q),
    .a_signed_q (a_signed_q),
    .b_signed_q (b_signed_q),
    .pair_add_q (pair_add_q),
    .acc_load_q (acc_load_q),
    .cas_q      (cas_q),
    .scan_out   (scan_out)
  );

  generate
    for (genvar i = 0; i < NUM_MUL; i++) begin : g_mul
      sop4_mul #(.A_W(A_W), .B_W(B_W), .P_W(P_W)) u_mul (
        .a        (a_q[i*A_W +: A_W]),
        .b        (b_q[i*B_W +: B_W]),
        .a_signed (a_signed_q),
        .b_signed (b_signed_q),
        .prod     (prods[i*P_W +: P_W])
      );
    end
  endgenerate

  sop4_combine #(.P_W(P_W), .RES_W(RES_W)) u_comb (
    .prods    (prods),
    .pair_add (pair_add_q),
    .acc_load (acc_load_q),
    .cas      (cas_q),
    .acc_fb   (result),
    .sum      (sum)
  );

  sop4_out_stage #(.RES_W(RES_W)) u_out (
    .clk    (clk),
    .arst_n (out_arst_n),
    .sclr   (sclr[1]),
    .en     (en),
    .sum    (sum),
    .res_q  (result)
  );
endmodule

// File: rtl/sop4_chk.sv
module sop4_chk #(
  parameter int A_W   = 18,
  parameter int RES_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic [1:0]       aclr,
  input logic [1:0]       sclr,
  input logic             scan_sel,
  input logic [A_W-1:0]   scan_in,
  input logic [A_W-1:0]   scan_out,
  input logic [RES_W-1:0] result
);
  logic [2:0] shift_run;
  logic       shift_now;

  assign shift_now = en & scan_sel & ~sclr[0] & ~aclr[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               shift_run <= '0;
    else if (!shift_now)      shift_run <= '0;
    else if (shift_run != 3'd4) shift_run <= shift_run + 3'd1;
  end

  // R6: head of the chain reaches the tail after four shifting edges
  assert_scan_depth_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_run == 3'd4 && !aclr[0]) |-> scan_out == $past(scan_in, 4));

  // R7: result frozen while disabled
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !sclr[1] && !aclr[1]) |=> (aclr[1] || result == $past(result)));

  // R8: synchronous clears take effect at the next edge
  assert_sclr_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclr[1] |=> result == '0);
  assert_sclr_in_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sclr[0] |=> scan_out == '0);

  // R9: asynchronous clear holds its stage at zero
  assert_aclr_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aclr[1] |-> result == '0);
  assert_aclr_in_R9: assert property (@(posedge clk) disable iff (!rst_n)
    aclr[0] |-> scan_out == '0);
endmodule

bind sop4_unit sop4_chk #(.A_W(A_W), .RES_W(RES_W)) u_sop4_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .aclr     (aclr),
  .sclr     (sclr),
  .scan_sel (scan_sel),
  .scan_in  (scan_in),
  .scan_out (scan_out),
  .result   (result)
);

// File: tb/tb_sop4_unit.sv
module tb_sop4_unit;
  localparam int A_W   = 18;
  localparam int B_W   = 18;
  localparam int RES_W = A_W + B_W + 4;

  logic               clk = 1'b0;
  logic               rst_n;
  logic               en;
  logic [1:0]         aclr, sclr;
  logic [4*A_W-1:0]   a_bus;
  logic [4*B_W-1:0]   b_bus;
  logic               a_signed, b_signed, acc_load, scan_sel;
  logic [1:0]         pair_add;
  logic [RES_W-1:0]   cas_in;
  logic [A_W-1:0]     scan_in;
  logic [A_W-1:0]     scan_out;
  logic [RES_W-1:0]   result;

  sop4_unit #(.A_W(A_W), .B_W(B_W)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .aclr(aclr), .sclr(sclr),
    .a_bus(a_bus), .b_bus(b_bus), .a_signed(a_signed), .b_signed(b_signed),
    .pair_add(pair_add), .acc_load(acc_load), .cas_in(cas_in),
    .scan_sel(scan_sel), .scan_in(scan_in), .scan_out(scan_out), .result(result)
  );

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    reported = 0;
  string tag      = "R9";

  // bench model of both register stages
  logic [A_W-1:0]   m_a [4];
  logic [B_W-1:0]   m_b [4];
  logic             m_sa, m_sb, m_ld;
  logic [1:0]       m_pa;
  logic [RES_W-1:0] m_cas, m_res;

  function automatic longint mulv(logic [A_W-1:0] a, logic [B_W-1:0] b,
                                  logic sa, logic sb);
    longint av, bv;
    av = sa ? longint'($signed(a)) : longint'(a);
    bv = sb ? longint'($signed(b)) : longint'(b);
    return av * bv;
  endfunction

  function automatic logic [RES_W-1:0] next_sum();
    longint p [4];
    longint tot;
    for (int i = 0; i < 4; i++) p[i] = mulv(m_a[i], m_b[i], m_sa, m_sb);
    tot = (m_pa[0] ? p[0] + p[1] : p[0] - p[1])
        + (m_pa[1] ? p[2] + p[3] : p[2] - p[3])
        + longint'($signed(m_cas))
        + (m_ld ? 64'sd0 : longint'($signed(m_res)));
    return tot[RES_W-1:0];
  endfunction

  task automatic model_clear_in();
    for (int i = 0; i < 4; i++) begin m_a[i] = '0; m_b[i] = '0; end
    m_sa = 0; m_sb = 0; m_ld = 0; m_pa = '0; m_cas = '0;
  endtask

  task automatic model_edge();
    logic [RES_W-1:0] nr;
    nr = m_res;
    if (aclr[1] || sclr[1]) nr = '0;
    else if (en)            nr = next_sum();
    if (aclr[0] || sclr[0]) model_clear_in();
    else if (en) begin
      for (int i = 3; i >= 0; i--) begin
        if (scan_sel) m_a[i] = (i == 0) ? scan_in : m_a[i-1];
        else          m_a[i] = a_bus[i*A_W +: A_W];
        m_b[i] = b_bus[i*B_W +: B_W];
      end
      m_sa = a_signed; m_sb = b_signed; m_ld = acc_load;
      m_pa = pair_add; m_cas = cas_in;
    end
    m_res = nr;
  endtask

  task automatic check(string t, logic [RES_W-1:0] act, logic [RES_W-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check({tag, " result"}, result, m_res);
    check({tag, " scan_out"}, RES_W'(scan_out), RES_W'(m_a[3]));
  endtask

  // one clock: model follows the edge, outputs compared at the falling edge
  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_outputs();
  endtask

  task automatic idle_inputs();
    en = 1; aclr = '0; sclr = '0; a_bus = '0; b_bus = '0;
    a_signed = 0; b_signed = 0; pair_add = 2'b11; acc_load = 1;
    cas_in = '0; scan_sel = 0; scan_in = '0;
  endtask

  function automatic logic [A_W-1:0] rnd_a();
    case ($urandom_range(0, 5))
      0:       return {1'b1, {(A_W-1){1'b0}}};
      1:       return '1;
      2:       return {1'b0, {(A_W-1){1'b1}}};
      default: return A_W'($urandom);
    endcase
  endfunction

  function automatic logic [B_W-1:0] rnd_b();
    case ($urandom_range(0, 5))
      0:       return {1'b1, {(B_W-1){1'b0}}};
      1:       return '1;
      2:       return {1'b0, {(B_W-1){1'b1}}};
      default: return B_W'($urandom);
    endcase
  endfunction

  task automatic rnd_inputs();
    for (int i = 0; i < 4; i++) begin
      a_bus[i*A_W +: A_W] = rnd_a();
      b_bus[i*B_W +: B_W] = rnd_b();
    end
    a_signed = 1'($urandom); b_signed = 1'($urandom);
    pair_add = 2'($urandom); acc_load = 1'($urandom);
    cas_in   = {8'($urandom), 32'($urandom)};
    scan_in  = A_W'($urandom);
    scan_sel = ($urandom_range(0, 4) == 0);
    en       = ($urandom_range(0, 9) != 0);
    sclr[0]  = ($urandom_range(0, 19) == 0);
    sclr[1]  = ($urandom_range(0, 19) == 0);
    aclr     = '0;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    idle_inputs();
    rst_n = 0;
    model_clear_in(); m_res = '0;
    repeat (3) @(negedge clk);
    tag = "R9";                       // reset state
    compare_outputs();
    rst_n = 1;

    // R1: signed corner, most negative times most negative, other products zero
    tag = "R1";
    a_bus[0 +: A_W] = {1'b1, {(A_W-1){1'b0}}};
    b_bus[0 +: B_W] = {1'b1, {(B_W-1){1'b0}}};
    a_signed = 1; b_signed = 1;
    step(); step();
    check("R1 signed min*min", result, RES_W'(longint'(1) <<< (A_W+B_W-2)));
    // R1: all ones read unsigned on A, signed (-1) on B
    a_bus = '1; b_bus = '1; a_signed = 0; b_signed = 1;
    step(); step();
    check("R1 unsigned*signed", result, RES_W'(-4 * ((longint'(1) <<< A_W) - 1)));

    // R2 and R3: subtract within each pair
    tag = "R2 R3";
    idle_inputs(); pair_add = 2'b00;
    for (int i = 0; i < 4; i++) begin
      a_bus[i*A_W +: A_W] = A_W'(i + 3);
      b_bus[i*B_W +: B_W] = B_W'(10);
    end
    step(); step();
    check("R2 R3 pair subtract", result, RES_W'(-20));
    pair_add = 2'b01; step(); step();
    check("R3 pair1 subtract only", result, RES_W'(70 - 10));

    // R4: accumulate with cascade, then load
    tag = "R4";
    cas_in = RES_W'(-5); pair_add = 2'b11; acc_load = 0;
    step(); step(); step();
    acc_load = 1; step(); step();
    check("R4 load drops feedback", result, RES_W'(180 - 5));

    // R5: latency of two edges
    tag = "R5";
    cas_in = RES_W'(1000); acc_load = 1;
    @(posedge clk); model_edge();
    @(negedge clk);
    check("R5 one edge later still old", result, RES_W'(175));
    compare_outputs();
    step();
    check("R5 two edges later", result, RES_W'(180 + 1000));

    // R6: scan chain, four shifts to the tail
    tag = "R6";
    idle_inputs(); scan_sel = 1;
    for (int k = 0; k < 6; k++) begin
      scan_in = A_W'(17 * (k + 1));
      step();
      if (k == 3) check("R6 head reaches tail", RES_W'(scan_out), RES_W'(17));
    end

    // R7: enable low freezes both stages
    tag = "R7";
    rnd_inputs(); en = 0; sclr = '0;
    for (int k = 0; k < 3; k++) step();

    // R8: synchronous clear with enable low
    tag = "R8";
    idle_inputs(); a_bus = '1; b_bus = '1; step(); step();
    en = 0; sclr = 2'b11; step();
    check("R8 clear beats enable", result, '0);

    // R9: asynchronous clear without a clock edge
    tag = "R9";
    idle_inputs(); a_bus = '1; b_bus = '1; scan_sel = 0; step(); step();
    aclr = 2'b11; #3;
    check("R9 result cleared async", result, '0);
    check("R9 scan_out cleared async", RES_W'(scan_out), '0);
    model_clear_in(); m_res = '0;
    step(); aclr = '0;

    // R10: accumulate maxima until the word wraps
    tag = "R10";
    idle_inputs(); a_bus = '1; b_bus = '1; acc_load = 0;
    cas_in = {1'b0, {(RES_W-1){1'b1}}};
    for (int k = 0; k < 6; k++) step();

    // random mix
    tag = "R1 R2 R3 R4 R6 R7 R8";
    for (int k = 0; k < 3000; k++) begin
      rnd_inputs();
      step();
    end
    report();
  end
endmodule